// File: doc/BRIEF.md
# Buffered Prescaled Reload Timer

This block is a time base for a larger chip. An up-counter advances once for every (divider + 1) enabled clock cycles. When the counter reaches the active period value it wraps to zero, and that wrap produces an update event. Both the divider and the period have a preload copy that software writes and an active copy that the hardware uses. The divider's active copy is refreshed only on an update event. The period's active copy is refreshed either on every write or only on an update event, as selected by a control bit.

Update events come from two sources: the counter wrap, and a software kick. A kick restarts the counter and the divider and forces the preload-to-active transfer. A sticky update flag records these events. Control bits can block update events entirely, keep kicks from raising the flag, or make the timer stop itself after one period. The outputs are a registered update pulse, an interrupt line, a one-cycle DMA request and a selectable trigger. All control and status goes through a plain write/read register port.

The register map is as follows. Address 0 is the control register. Address 1 holds the interrupt and DMA enables. Address 2 is the flag. Address 3 is the kick strobe. Address 4 is the counter. Address 5 is the divider preload. Address 6 is the period preload. A write takes effect at the clock edge on which `wr_en` is high. Reads are combinational from `rd_addr`.

Top module: `tick_timer`

## Requirements
- R1: The counter is address 4, bits 15:0. It counts 0, 1, …, P and then wraps to 0, where P is the active period. It advances once every D+1 enabled cycles, where D is the active divider. Control bit 0 (run) is written at edge E0. The internal enable becomes active after edge E1, and the first advance can happen at edge E2.
- R2: A write to the divider preload (address 5) leaves the active divider unchanged until the next update event.
- R3: Control bit 4 (period buffering) selects how the period is used. With the bit at 0, the period preload (address 6) takes effect on the next count. With the bit at 1, the active period is loaded from the preload only on an update event.
- R4: With control bit 1 (update block) set, no update pulse occurs, no flag is set and no active register is reloaded. A kick still clears the counter and the divider count, and the divide ratio stays the same.
- R5: With control bit 2 (overflow-only) set, only a counter wrap sets the flag. A kick still produces the update pulse and the reload, but sets no flag.
- R6: Writing 1 to address 3, bit 0 (kick) clears the counter and the divider count, reloads the active registers, and produces a single update pulse. The kick needs no clearing write.
- R7: With control bit 3 (one-shot) set, an update event clears run (control bit 0) and the internal enable at that same edge, so counting stops.
- R8: After reset the period preload reads 0xFFFF and the divider and counter read 0. While the active period is 0, the counter does not move.
- R9: The flag at address 2, bit 0 stays set until a write of 0 to it. Writing 1 has no effect. With control bit 5 (mirror) set, the counter read shows the flag in bit 31 with no delay; otherwise bit 31 reads 0.
- R10: `irq` is high while the flag is set and address 1, bit 0 is 1. `dma_req` pulses for one cycle on each flag-setting update when address 1, bit 1 is 1.
- R11: Control bits 8:6 select `trig_out`. Value 000 gives the kick pulse, 001 gives the internal enable, 010 gives the update pulse, and any other value gives 0.
- R12: A write to address 4 loads the counter, and counting continues from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Combinational read data |
| upd_pulse | output | 1 | One-cycle update event, registered |
| irq | output | 1 | Interrupt: flag AND interrupt enable |
| dma_req | output | 1 | One-cycle DMA request |
| trig_out | output | 1 | Selected trigger output |

## Verification
The checker watches several properties on every cycle:
- the counter only steps by one or returns to zero when no write lands;
- the internal enable always trails run;
- a frozen counter while the period is zero;
- the flag staying sticky;
- DMA requests coinciding with the flag;
- no update pulse while updates are blocked;
- one-shot stopping run.

Only the bench scenarios can show the arithmetic of the count sequence for several divider and period pairs, and when deferred divider and period values take effect. The same holds for the kick's effect on the divide ratio, flag suppression for kicks, mirroring in the counter read, and the trigger selections.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_IEN    = 3'd1;
    localparam logic [ADDR_W-1:0] A_FLAG   = 3'd2;
    localparam logic [ADDR_W-1:0] A_KICK   = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_DIV    = 3'd5;
    localparam logic [ADDR_W-1:0] A_PERIOD = 3'd6;

    typedef enum logic [2:0] {
        TRG_KICK   = 3'd0,
        TRG_ENABLE = 3'd1,
        TRG_UPDATE = 3'd2
    } trig_sel_e;

    // control bits 8:1, packed MSB first; bit 0 (run) is held separately
    typedef struct packed {
        logic [2:0] trig_sel;
        logic       mirror;
        logic       per_buf;
        logic       one_shot;
        logic       ovf_only;
        logic       upd_block;
    } ctrl_t;

endpackage

// File: rtl/tick_timer_psc.sv
module tick_timer_psc #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clear,
    input  logic             load,
    input  logic [DIV_W-1:0] ratio_pre,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] ratio;
        logic [DIV_W-1:0] cnt;
    } psc_st_t;

    psc_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = 1'b0;
        if (clear) begin
            s_d.cnt = '0;
        end else if (en) begin
            if (s_q.cnt == s_q.ratio) begin
                s_d.cnt = '0;
                tick    = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        if (load) begin
            s_d.ratio = ratio_pre;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/tick_timer_cnt.sv
module tick_timer_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             load,
    input  logic             per_buf,
    input  logic [CNT_W-1:0] per_pre,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_act,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        per_act = per_buf ? s_q.shadow : per_pre;
        wrap    = tick && (s_q.cnt == per_act);
        if (clear) begin
            s_d.cnt = '0;
        end else if (wr) begin
            s_d.cnt = wdata;
        end else if (tick) begin
            s_d.cnt = wrap ? '0 : s_q.cnt + 1'b1;
        end
        if (load) begin
            s_d.shadow = per_pre;
        end
    end

    assign cnt = s_q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.shadow <= '1;
            s_q.cnt    <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/tick_timer_evt.sv
module tick_timer_evt
    import tick_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wrap,
    input  logic       kick,
    input  logic       upd_block,
    input  logic       ovf_only,
    input  logic       one_shot,
    input  logic       dma_en,
    input  logic       flag_clr,
    input  logic [2:0] trig_sel,
    input  logic       cnt_en,
    output logic       uev,
    output logic       stop_run,
    output logic       upd_pulse,
    output logic       flag,
    output logic       dma_req,
    output logic       trig
);
    typedef struct packed {
        logic upd;
        logic kick;
        logic flag;
        logic dma;
    } evt_st_t;

    evt_st_t s_d, s_q;
    logic    flag_set;

    always_comb begin
        uev      = !upd_block && (wrap || kick);
        flag_set = !upd_block && (wrap || (kick && !ovf_only));
        stop_run = uev && one_shot;
        s_d      = s_q;
        s_d.upd  = uev;
        s_d.kick = kick;
        s_d.dma  = flag_set && dma_en;
        if (flag_set) begin
            s_d.flag = 1'b1;
        end else if (flag_clr) begin
            s_d.flag = 1'b0;
        end
        case (trig_sel_e'(trig_sel))
            TRG_KICK:   trig = s_q.kick;
            TRG_ENABLE: trig = cnt_en;
            TRG_UPDATE: trig = s_q.upd;
            default:    trig = 1'b0;
        endcase
    end

    assign upd_pulse = s_q.upd;
    assign flag      = s_q.flag;
    assign dma_req   = s_q.dma;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 16,
    localparam int WD_W = (CNT_W > DIV_W) ? CNT_W : DIV_W,
    localparam int RD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WD_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [RD_W-1:0]   rd_data,
    output logic              upd_pulse,
    output logic              irq,
    output logic              dma_req,
    output logic              trig_out
);
    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t            ctrl;
        logic             run;
        logic             cnt_en;
        logic             irq_en;
        logic             dma_en;
        logic [DIV_W-1:0] div_pre;
        logic [CNT_W-1:0] per_pre;
    } reg_st_t;

    reg_st_t          r_d, r_q;
    logic             wr_ctrl, wr_cnt, kick, flag_clr;
    logic             tick, wrap, uev, stop_run, flag, psc_en;
    logic [CNT_W-1:0] cnt, per_act;

    always_comb begin
        wr_ctrl  = wr_en && (wr_addr == A_CTRL);
        wr_cnt   = wr_en && (wr_addr == A_COUNT);
        kick     = wr_en && (wr_addr == A_KICK) && wr_data[0];
        flag_clr = wr_en && (wr_addr == A_FLAG) && !wr_data[0];
        psc_en   = r_q.cnt_en && (per_act != '0);

        r_d = r_q;
        if (wr_ctrl) begin
            r_d.ctrl = ctrl_t'(wr_data[CTRL_W:1]);
            r_d.run  = wr_data[0];
        end
        if (wr_en && (wr_addr == A_IEN)) begin
            r_d.irq_en = wr_data[0];
            r_d.dma_en = wr_data[1];
        end
        if (wr_en && (wr_addr == A_DIV)) begin
            r_d.div_pre = wr_data[DIV_W-1:0];
        end
        if (wr_en && (wr_addr == A_PERIOD)) begin
            r_d.per_pre = wr_data[CNT_W-1:0];
        end
        if (stop_run) begin
            r_d.run = 1'b0;
        end
        r_d.cnt_en = r_q.run && r_d.run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.per_pre <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    tick_timer_psc #(.DIV_W(DIV_W)) u_psc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (psc_en),
        .clear     (kick),
        .load      (uev),
        .ratio_pre (r_q.div_pre),
        .tick      (tick)
    );

    tick_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clear   (kick),
        .wr      (wr_cnt),
        .wdata   (wr_data[CNT_W-1:0]),
        .load    (uev),
        .per_buf (r_q.ctrl.per_buf),
        .per_pre (r_q.per_pre),
        .cnt     (cnt),
        .per_act (per_act),
        .wrap    (wrap)
    );

    tick_timer_evt u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap      (wrap),
        .kick      (kick),
        .upd_block (r_q.ctrl.upd_block),
        .ovf_only  (r_q.ctrl.ovf_only),
        .one_shot  (r_q.ctrl.one_shot),
        .dma_en    (r_q.dma_en),
        .flag_clr  (flag_clr),
        .trig_sel  (r_q.ctrl.trig_sel),
        .cnt_en    (r_q.cnt_en),
        .uev       (uev),
        .stop_run  (stop_run),
        .upd_pulse (upd_pulse),
        .flag      (flag),
        .dma_req   (dma_req),
        .trig      (trig_out)
    );

    assign irq = flag && r_q.irq_en;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:   rd_data[CTRL_W:0] = {r_q.ctrl, r_q.run};
            A_IEN:    rd_data[1:0] = {r_q.dma_en, r_q.irq_en};
            A_FLAG:   rd_data[0] = flag;
            A_COUNT: begin
                rd_data[CNT_W-1:0] = cnt;
                rd_data[RD_W-1]    = r_q.ctrl.mirror && flag;
            end
            A_DIV:    rd_data[DIV_W-1:0] = r_q.div_pre;
            A_PERIOD: rd_data[CNT_W-1:0] = r_q.per_pre;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             any_wr,
    input logic             flag_clr,
    input logic             run,
    input logic             cnt_en,
    input logic             flag,
    input logic             upd_pulse,
    input logic             dma_req,
    input logic             upd_block,
    input logic             one_shot,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per_act
);
    // R1: without writes the counter only steps by one or returns to zero
    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(any_wr) && (cnt != $past(cnt))) |-> ((cnt == $past(cnt) + 1'b1) || (cnt == '0)));

    // R1: internal enable trails run by a cycle
    assert_enable_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |-> ($past(run) && run));

    // R4: blocked updates produce no pulse
    assert_no_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(upd_block) |-> !upd_pulse);

    // R7: one-shot update stops the timer
    assert_one_shot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && $past(one_shot) && !$past(any_wr)) |-> !run);

    // R8: zero period freezes the counter
    assert_zero_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((per_act == '0) && !any_wr) |=> $stable(cnt));

    // R9: flag is sticky until cleared
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    // R10: a DMA request always accompanies a set flag
    assert_dma_with_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> flag);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_wr    (wr_en),
    .flag_clr  (flag_clr),
    .run       (r_q.run),
    .cnt_en    (r_q.cnt_en),
    .flag      (flag),
    .upd_pulse (upd_pulse),
    .dma_req   (dma_req),
    .upd_block (r_q.ctrl.upd_block),
    .one_shot  (r_q.ctrl.one_shot),
    .cnt       (cnt),
    .per_act   (per_act)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/100ps
module tick_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        upd_pulse, irq, dma_req, trig_out;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .upd_pulse(upd_pulse), .irq(irq),
        .dma_req(dma_req), .trig_out(trig_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #0.2;
        v = rd_data;
    endtask

    task automatic do_reset();
        wr_en = 1'b0;
        rst_n = 1'b0;
        step(2);
        @(negedge clk);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic sweep(input int per, input int dv, input int n);
        logic [31:0] v;
        do_reset();
        wr(3'd6, 16'(per));
        wr(3'd5, 16'(dv));
        wr(3'd3, 16'h1);
        wr(3'd0, 16'h1);
        for (int k = 1; k <= n; k++) begin
            step(1);
            rd(3'd4, v);
            chk("R1 count", v & 32'hFFFF, 32'(((k - 1) / (dv + 1)) % (per + 1)));
            chk("R1 update", 32'(upd_pulse),
                32'((k > 1) && ((k - 1) % ((dv + 1) * (per + 1)) == 0)));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;

        // R8 reset values
        do_reset();
        rd(3'd6, v); chk("R8 period reset", v, 32'hFFFF);
        rd(3'd5, v); chk("R8 divider reset", v, 0);
        rd(3'd4, v); chk("R8 count reset", v, 0);
        chk("R10 irq reset", 32'(irq), 0);
        chk("R6 update reset", 32'(upd_pulse), 0);

        // R1 count sweeps
        sweep(9, 0, 24);
        sweep(4, 2, 40);
        sweep(2, 1, 30);
        sweep(6, 3, 60);

        // R2 deferred divider
        do_reset();
        wr(3'd6, 16'd5);
        wr(3'd5, 16'd1);
        wr(3'd0, 16'h1);
        step(6); rd(3'd4, v); chk("R2 old ratio", v, 5);
        step(1); rd(3'd4, v); chk("R2 wrap", v, 0);
        step(1); rd(3'd4, v); chk("R2 new ratio hold", v, 0);
        step(1); rd(3'd4, v); chk("R2 new ratio step", v, 1);
        step(2); rd(3'd4, v); chk("R2 new ratio", v, 2);

        // R3 buffered period
        do_reset();
        wr(3'd0, 16'h10);
        wr(3'd6, 16'd3);
        wr(3'd3, 16'h1);
        wr(3'd0, 16'h11);
        step(2);
        wr(3'd6, 16'd9);
        rd(3'd4, v); chk("R3 buf count", v, 2);
        step(2); rd(3'd4, v); chk("R3 buf old period", v, 0);
        step(9); rd(3'd4, v); chk("R3 buf new top", v, 9);
        step(1); rd(3'd4, v); chk("R3 buf new wrap", v, 0);
        // R3 immediate period
        do_reset();
        wr(3'd6, 16'd3);
        wr(3'd0, 16'h1);
        step(2);
        wr(3'd6, 16'd9);
        step(2); rd(3'd4, v); chk("R3 immediate period", v, 4);

        // R4 update block
        do_reset();
        wr(3'd5, 16'd1);
        wr(3'd6, 16'd3);
        wr(3'd0, 16'h3);
        step(4); rd(3'd4, v); chk("R4 count top", v, 3);
        step(1); rd(3'd4, v); chk("R4 wrap count", v, 0);
        chk("R4 no pulse", 32'(upd_pulse), 0);
        rd(3'd2, v); chk("R4 no flag", v, 0);
        step(2); rd(3'd4, v); chk("R4 ratio kept", v, 2);
        wr(3'd3, 16'h1);
        rd(3'd4, v); chk("R4 kick clears", v, 0);
        chk("R4 kick no pulse", 32'(upd_pulse), 0);
        rd(3'd2, v); chk("R4 kick no flag", v, 0);
        step(1); rd(3'd4, v); chk("R4 kick ratio unchanged", v, 1);

        // R5 R6 R9 R10 R11
        do_reset();
        wr(3'd1, 16'h2);
        wr(3'd6, 16'd2);
        wr(3'd5, 16'd2);
        wr(3'd0, 16'h4);
        wr(3'd3, 16'h1);
        chk("R6 kick pulse", 32'(upd_pulse), 1);
        chk("R11 trig kick", 32'(trig_out), 1);
        rd(3'd2, v); chk("R5 kick no flag", v, 0);
        chk("R10 no dma on kick", 32'(dma_req), 0);
        step(1);
        chk("R6 pulse self clears", 32'(upd_pulse), 0);
        chk("R11 trig kick clears", 32'(trig_out), 0);
        wr(3'd0, 16'h5);
        step(3); rd(3'd4, v); chk("R6 count hold", v, 0);
        step(1); rd(3'd4, v); chk("R6 ratio loaded", v, 1);
        step(5); rd(3'd4, v); chk("R6 count top", v, 2);
        step(1); rd(3'd4, v); chk("R5 wrap count", v & 32'hFFFF, 0);
        chk("R9 mirror off", v >> 31, 0);
        rd(3'd2, v); chk("R5 wrap flag", v, 1);
        chk("R10 dma pulse", 32'(dma_req), 1);
        chk("R10 irq disabled", 32'(irq), 0);
        step(1);
        chk("R10 dma one cycle", 32'(dma_req), 0);
        wr(3'd0, 16'h25);
        rd(3'd4, v); chk("R9 mirror on", v >> 31, 1);
        wr(3'd2, 16'h1);
        rd(3'd2, v); chk("R9 write one ignored", v, 1);
        wr(3'd1, 16'h3);
        chk("R10 irq on", 32'(irq), 1);
        wr(3'd2, 16'h0);
        rd(3'd2, v); chk("R9 cleared", v, 0);
        chk("R10 irq off", 32'(irq), 0);
        rd(3'd4, v); chk("R9 mirror follows", v >> 31, 0);

        // R7 one-shot, R11 enable trigger
        do_reset();
        wr(3'd6, 16'd2);
        wr(3'd0, 16'h49);
        chk("R11 enable not yet", 32'(trig_out), 0);
        step(1); chk("R11 enable delayed", 32'(trig_out), 1);
        step(2); rd(3'd4, v); chk("R7 count top", v, 2);
        step(1); rd(3'd4, v); chk("R7 wrap", v, 0);
        chk("R7 pulse", 32'(upd_pulse), 1);
        chk("R7 enable off", 32'(trig_out), 0);
        rd(3'd0, v); chk("R7 run cleared", v & 32'h1, 0);
        step(4); rd(3'd4, v); chk("R7 stopped", v, 0);

        // R8 zero period
        do_reset();
        wr(3'd6, 16'd0);
        wr(3'd0, 16'h1);
        step(6); rd(3'd4, v); chk("R8 blocked", v, 0);
        chk("R8 no pulse", 32'(upd_pulse), 0);
        wr(3'd6, 16'd3);
        step(1); rd(3'd4, v); chk("R8 resumes", v, 1);

        // R12 count write, R11 update trigger
        do_reset();
        wr(3'd4, 16'hFFFD);
        wr(3'd0, 16'h81);
        step(1); rd(3'd4, v); chk("R12 loaded", v, 32'hFFFD);
        step(2); rd(3'd4, v); chk("R12 top", v, 32'hFFFF);
        step(1); rd(3'd4, v); chk("R12 wrap", v, 0);
        chk("R11 trig update", 32'(trig_out), 1);
        step(1); chk("R11 trig update clears", 32'(trig_out), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule